// File: doc/BRIEF.md
# Page-Mode Asynchronous Read Sequencer

This block runs read cycles on an asynchronous memory device that supports page-mode bursts. A host offers a byte address with a valid/ready handshake. The block then drives the device address, pulls chip select and read strobe low, and holds them for a programmed number of clock cycles. On the last of those cycles it registers the device data and returns it to the host with a one-cycle valid pulse.

The block remembers which aligned page the device currently has open. When page mode is enabled and a new read lands in that page, the block uses a short in-page wait count. Any other read uses the longer first-access count and records the new page. The page size can be 4, 8, 16 or 32 bytes, and each page is aligned to its own size. The open page is forgotten when the strobes are released, and also when the page-mode or page-size setting changes. A flag for 16-bit-wide devices forces address bit 0 to zero.

Top module: `page_read_seq`

## Requirements
- R1: A request accepted at a clock edge drives `mem_cs_n` and `mem_rd_n` low from the next cycle, for exactly N cycles. The memory data present in the N-th cycle appears on `rd_data`, with `rd_valid` high for one cycle, in the cycle after that.
- R2: N is `cfg_page_cyc` for a page hit and `cfg_first_cyc` otherwise. A hit needs page mode enabled, a valid open page, and a page address equal to the open one.
- R3: The `cfg_psize` code k (0,1,2,3) selects a page of 4, 8, 16 or 32 bytes. The page address is `addr[23:2+k]`, so two reads that differ only in `addr[1+k:0]` share a page.
- R4: With `cfg_page_en` low, every read uses `cfg_first_cyc`.
- R5: A wait count of 0 behaves as 1 cycle. Counts go up to 15.
- R6: A request accepted in the last strobe cycle keeps both strobes low without a gap. When no request is pending at the last cycle, both strobes go high and `req_ready` is high while they are high.
- R7: When the strobes are released, the open page is invalidated, so the next read uses first-access timing.
- R8: A change of `cfg_psize` or `cfg_page_en` invalidates the open page.
- R9: With `cfg_half_wide` high at acceptance, `mem_addr[0]` is 0 for that access, and `mem_addr[23:1]` equals the request address bits.
- R10: During and after reset, `mem_cs_n` and `mem_rd_n` are high, `rd_valid` is low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host read request |
| req_addr | input | 24 | Byte address of the request |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| cfg_page_en | input | 1 | Enables in-page timing |
| cfg_psize | input | 2 | Page size code: 0=4, 1=8, 2=16, 3=32 bytes |
| cfg_first_cyc | input | 4 | Wait count for the first access to a page |
| cfg_page_cyc | input | 4 | Wait count for a read in the open page |
| cfg_half_wide | input | 1 | 16-bit device, address bit 0 forced to zero |
| mem_addr | output | 24 | Device address |
| mem_cs_n | output | 1 | Device chip select, active low |
| mem_rd_n | output | 1 | Device read strobe, active low |
| mem_data | input | 16 | Device read data |
| rd_data | output | 16 | Captured read data |
| rd_valid | output | 1 | One-cycle pulse marking rd_data |

## Verification
A corrupt open-page tag or valid bit shows up only as a wrong strobe length on the following read. For example, a stale page turns a first access into an in-page access. The `rd_valid` pulse then arrives early or late by the difference of the two counts, within that one read. A wrong wait counter moves the data pulse on every read and can capture data from the wrong cycle. So the latency of each returned item is compared with a cycle count worked out from the page rules. Chip select continuity across bursts is counted separately.

// File: rtl/pgrd_pkg.sv
package pgrd_pkg;
  typedef enum logic {
    SEQ_IDLE   = 1'b0,
    SEQ_ACCESS = 1'b1
  } seq_state_e;
endpackage

// File: rtl/pgrd_page_tracker.sv
module pgrd_page_tracker #(
  parameter int ADDR_W  = 24,
  parameter int PSIZE_W = 2,
  parameter int MIN_OFS = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  look_addr,
  input  logic               cfg_en,
  input  logic [PSIZE_W-1:0] cfg_psize,
  input  logic               load,
  input  logic               drop,
  output logic               hit
);
  localparam int TAG_W = ADDR_W - MIN_OFS;

  logic [TAG_W-1:0]   keep_mask;
  logic [TAG_W-1:0]   look_tag;
  logic [TAG_W-1:0]   tag_q, tag_d;
  logic               vld_q, vld_d;
  logic               en_q;
  logic [PSIZE_W-1:0] psize_q;
  logic               cfg_chg;

  // clear the tag bits that lie inside the page
  always_comb begin
    for (int i = 0; i < TAG_W; i++) begin
      keep_mask[i] = (i >= int'(cfg_psize));
    end
  end

  assign look_tag = look_addr[ADDR_W-1:MIN_OFS] & keep_mask;
  assign cfg_chg  = (en_q != cfg_en) || (psize_q != cfg_psize);
  assign hit      = vld_q && cfg_en && !cfg_chg && (look_tag == tag_q);

  always_comb begin
    tag_d = tag_q;
    vld_d = vld_q;
    if (cfg_chg || drop) vld_d = 1'b0;
    if (load) begin
      tag_d = look_tag;
      vld_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_q   <= '0;
      vld_q   <= 1'b0;
      en_q    <= 1'b0;
      psize_q <= '0;
    end else begin
      tag_q   <= tag_d;
      vld_q   <= vld_d;
      en_q    <= cfg_en;
      psize_q <= cfg_psize;
    end
  end
endmodule

// File: rtl/pgrd_wait_timer.sv
module pgrd_wait_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  output logic             last
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign last   = (cnt_q == ONE);
  assign cnt_en = load || (run && (cnt_q > ONE));

  always_comb begin
    if (load) cnt_d = (load_val == '0) ? ONE : load_val;
    else      cnt_d = cnt_q - ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= ONE;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/page_read_seq.sv
module page_read_seq #(
  parameter int ADDR_W  = 24,
  parameter int DATA_W  = 16,
  parameter int CNT_W   = 4,
  parameter int PSIZE_W = 2,
  parameter int MIN_OFS = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [ADDR_W-1:0]  req_addr,
  output logic               req_ready,
  input  logic               cfg_page_en,
  input  logic [PSIZE_W-1:0] cfg_psize,
  input  logic [CNT_W-1:0]   cfg_first_cyc,
  input  logic [CNT_W-1:0]   cfg_page_cyc,
  input  logic               cfg_half_wide,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic               mem_cs_n,
  output logic               mem_rd_n,
  input  logic [DATA_W-1:0]  mem_data,
  output logic [DATA_W-1:0]  rd_data,
  output logic               rd_valid
);
  import pgrd_pkg::*;

  seq_state_e        state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] data_q;
  logic              vld_q;
  logic              active, last, fin, accept, page_hit;
  logic [CNT_W-1:0]  wait_sel;

  assign active    = (state_q == SEQ_ACCESS);
  assign req_ready = !active || last;
  assign accept    = req_valid && req_ready;
  assign fin       = active && last;
  assign wait_sel  = page_hit ? cfg_page_cyc : cfg_first_cyc;

  pgrd_page_tracker #(
    .ADDR_W (ADDR_W),
    .PSIZE_W(PSIZE_W),
    .MIN_OFS(MIN_OFS)
  ) page_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .look_addr(req_addr),
    .cfg_en   (cfg_page_en),
    .cfg_psize(cfg_psize),
    .load     (accept),
    .drop     (fin && !accept),
    .hit      (page_hit)
  );

  pgrd_wait_timer #(
    .CNT_W(CNT_W)
  ) timer_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (accept),
    .load_val(wait_sel),
    .run     (active),
    .last    (last)
  );

  always_comb begin
    state_d = state_q;
    if (accept)   state_d = SEQ_ACCESS;
    else if (fin) state_d = SEQ_IDLE;
    addr_d = req_addr;
    if (cfg_half_wide) addr_d[0] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      vld_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      vld_q   <= fin;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      addr_q <= '0;
    else if (accept) addr_q <= addr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   data_q <= '0;
    else if (fin) data_q <= mem_data;
  end

  assign mem_addr = addr_q;
  assign mem_cs_n = !active;
  assign mem_rd_n = !active;
  assign rd_data  = data_q;
  assign rd_valid = vld_q;
endmodule

module page_read_seq_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              cfg_half_wide,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_cs_n,
  input logic              mem_rd_n,
  input logic              rd_valid
);
  logic [4:0] win_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      win_q <= '0;
    else if (req_valid && req_ready) win_q <= 5'd1;
    else if (!mem_cs_n && win_q != 5'd31) win_q <= win_q + 5'd1;
  end

  // R1
  accept_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!mem_cs_n && !mem_rd_n));

  // R1
  valid_after_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_valid) |-> $past(!mem_cs_n));

  // R5
  wait_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_cs_n |-> (win_q <= 5'd15 && win_q != 5'd0));

  // R6
  idle_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cs_n |-> req_ready);

  // R9
  half_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && cfg_half_wide) |=> !mem_addr[0]);
endmodule

bind page_read_seq page_read_seq_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .cfg_half_wide(cfg_half_wide),
  .mem_addr     (mem_addr),
  .mem_cs_n     (mem_cs_n),
  .mem_rd_n     (mem_rd_n),
  .rd_valid     (rd_valid)
);

// File: tb/page_read_seq_tb_top.sv
module page_read_seq_tb_top;
  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [23:0] req_addr;
  logic        req_ready;
  logic        cfg_page_en;
  logic [1:0]  cfg_psize;
  logic [3:0]  cfg_first_cyc;
  logic [3:0]  cfg_page_cyc;
  logic        cfg_half_wide;
  logic [23:0] mem_addr;
  logic        mem_cs_n;
  logic        mem_rd_n;
  logic [15:0] mem_data;
  logic [15:0] rd_data;
  logic        rd_valid;

  typedef struct {
    logic [15:0] data;
    int          due;
    string       req;
  } exp_t;

  exp_t q[$];
  int   n_chk  = 0;
  int   n_fail = 0;
  int   cyc    = 0;
  int   cs_hi  = 0;

  function automatic logic [15:0] mdl(input logic [23:0] a);
    return {a[7:0], ~a[7:0]} ^ {a[23:16], a[15:8]};
  endfunction

  assign mem_data = mdl(mem_addr);

  page_read_seq dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_ready(req_ready), .cfg_page_en(cfg_page_en), .cfg_psize(cfg_psize),
    .cfg_first_cyc(cfg_first_cyc), .cfg_page_cyc(cfg_page_cyc),
    .cfg_half_wide(cfg_half_wide), .mem_addr(mem_addr), .mem_cs_n(mem_cs_n),
    .mem_rd_n(mem_rd_n), .mem_data(mem_data), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // monitor: pop and compare each returned item
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_cs_n) cs_hi++;
      if (rd_valid) begin
        if (q.size() == 0) begin
          check(1'b0, "R1", "unexpected rd_valid", 1, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          check(rd_data == e.data, e.req, "rd_data", int'(rd_data), int'(e.data));
          check(cyc == e.due, e.req, "data cycle", cyc, e.due);
        end
      end
    end
  end

  // driver: issue one read, push its expected result
  task automatic issue(input logic [23:0] a, input int lat, input string req);
    exp_t e;
    logic [23:0] eff;
    @(negedge clk);
    req_addr  = a;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    eff = a;
    if (cfg_half_wide) eff[0] = 1'b0;
    e.data = mdl(eff);
    e.due  = cyc + lat;
    e.req  = req;
    q.push_back(e);
    check(mem_cs_n == 1'b0 && mem_rd_n == 1'b0, "R1", "strobes low", int'({mem_cs_n, mem_rd_n}), 0);
    check(mem_addr == eff, cfg_half_wide ? "R9" : "R1", "mem_addr", int'(mem_addr), int'(eff));
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "WDOG", "watchdog expired", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int hi0;
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0;
    cfg_page_en = 1'b1; cfg_psize = 2'd0; cfg_first_cyc = 4'd5;
    cfg_page_cyc = 4'd2; cfg_half_wide = 1'b0;
    repeat (3) @(negedge clk);
    // R10 reset state
    check(mem_cs_n && mem_rd_n, "R10", "strobes in reset", int'({mem_cs_n, mem_rd_n}), 3);
    check(!rd_valid && req_ready, "R10", "valid/ready in reset", int'({rd_valid, req_ready}), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(mem_cs_n && !rd_valid && req_ready, "R10", "after reset", int'({mem_cs_n, rd_valid, req_ready}), 5);

    // R2 R3 R6: 4-byte pages, back-to-back burst
    issue(24'h000100, 5, "R2");
    hi0 = cs_hi;
    issue(24'h000102, 2, "R2");
    issue(24'h000103, 2, "R3");
    issue(24'h000104, 5, "R3");
    issue(24'h000105, 2, "R2");
    check(cs_hi == hi0, "R6", "strobe gap in burst", cs_hi - hi0, 0);
    drain();
    check(mem_cs_n && req_ready, "R6", "release when idle", int'({mem_cs_n, req_ready}), 3);

    // R7: same page after release is a first access
    issue(24'h000105, 5, "R7");
    drain();

    // R3: 32-byte page boundary
    cfg_psize = 2'd3;
    @(negedge clk);
    issue(24'h001000, 5, "R3");
    issue(24'h00101F, 2, "R3");
    issue(24'h001020, 5, "R3");
    drain();

    // R3: 8-byte page
    cfg_psize = 2'd1;
    @(negedge clk);
    issue(24'h006006, 5, "R3");
    issue(24'h006007, 2, "R3");
    issue(24'h006008, 5, "R3");
    drain();

    // R4: page mode off
    cfg_page_en = 1'b0;
    @(negedge clk);
    issue(24'h002000, 5, "R4");
    issue(24'h002001, 5, "R4");
    drain();
    cfg_page_en = 1'b1;

    // R5: zero counts and maximum count
    cfg_first_cyc = 4'd0; cfg_page_cyc = 4'd0;
    @(negedge clk);
    issue(24'h003000, 1, "R5");
    issue(24'h003002, 1, "R5");
    drain();
    cfg_first_cyc = 4'd15; cfg_page_cyc = 4'd3;
    @(negedge clk);
    issue(24'h003100, 15, "R5");
    issue(24'h003101, 3, "R5");
    drain();
    cfg_first_cyc = 4'd5; cfg_page_cyc = 4'd2;

    // R9: 16-bit device
    cfg_half_wide = 1'b1;
    @(negedge clk);
    issue(24'h004003, 5, "R9");
    issue(24'h004001, 2, "R9");
    drain();
    cfg_half_wide = 1'b0;

    // R8: page size change inside a burst
    cfg_psize = 2'd1;
    @(negedge clk);
    issue(24'h005000, 5, "R8");
    cfg_psize = 2'd2;
    issue(24'h005001, 5, "R8");
    issue(24'h005002, 2, "R8");
    drain();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule